// File: doc/BRIEF.md
# Handshaked Byte-Stream Command Engine

This block is the device side of a byte-serial command channel. A host exchanges one byte at a time through a shift-register data path. Two active-low lines in an eight-bit port image pace every exchange: the host drives the request bit, and the engine drives the acknowledge bit. Each time the host writes the port image, it also presents the shift-register direction (host drives or host reads) and the byte it is shifting out.

The engine steps through idle, command collection, handler wait and response delivery. A packet starts with a command byte. A lookup table gives the argument and response lengths for each command. A table entry can also mark a length as variable, in which case an extra count byte carries it on the wire.

Once all arguments are in, the engine strobes them to an external handler. It then takes the handler's answer and returns it one byte per handshake. When the handler reports the command as unknown, the engine makes up an all-zero answer.

Top module: `hsk_cmd_engine`

## Requirements
- R1: After reset the port image reads 0x18, with both handshake lines released high. The engine is idle, and `sr_irq`, `disp_valid` and `sr_byte` are all zero.
- R2: Release rule. A host write that differs from the current image, with the request bit (bit 4) at 1 and the acknowledge bit (bit 3) at 0, makes the image equal the written value with bit 3 forced to 1. This write causes no exchange and no interrupt.
- R3: A host write equal to the current image has no effect. A differing write with bits 4 and 3 both 1 or both 0 is copied into the image and causes no exchange and no interrupt.
- R4: Request rule. A differing host write with bit 4 at 0 and bit 3 at 1 is a byte request. From the next cycle the image equals the written value with bit 3 cleared, even when the byte itself is rejected.
- R5: While idle or collecting a command, a byte request whose direction is host-reads (`host_sr_out` = 0) is a protocol error. The engine stays in its state, stores nothing and raises no interrupt.
- R6: In idle, a host-drives byte becomes the command, and its table entry is loaded. Default table: for a command with bits [7:6] = 11 both lengths are variable (entry 0xFF). Otherwise the argument length is bits [2:0] and the response length is bits [5:3].
- R7: With a variable argument length, the first byte after the command is the argument count. The following bytes are arguments.
- R8: Argument bytes past the buffer depth (32) are discarded. The dispatched count saturates at 32, and completion still waits for the full count.
- R9: When the argument count is reached, `disp_valid` pulses for one cycle with the command, the count and the stored arguments. With a zero length, this happens directly after the command byte.
- R10: A handler answer replaces the response. If `hdl_unknown` is set, the response is a table-length run of zero bytes, or size zero when the table length is variable.
- R11: With a variable response length, the first byte returned is the response size. The response bytes follow it.
- R12: While the response is being returned, a byte request with direction host-drives is a protocol error. The engine sends nothing, leaves `sr_byte` unchanged and raises no interrupt.
- R13: Every accepted byte exchange pulses `sr_irq` for one cycle. Nothing else pulses it.
- R14: The engine returns to idle after the last response byte. Byte requests made while it waits for the handler are ignored, and the image is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host writes the port image this cycle |
| host_pb | input | 8 | Port image value written by the host |
| host_sr_out | input | 1 | Shift direction: 1 = host drives, 0 = host reads |
| host_sr_byte | input | 8 | Byte the host shifts toward the engine |
| pb_image | output | 8 | Current port image, including the acknowledge bit |
| sr_byte | output | 8 | Byte the engine places for the host to read |
| sr_irq | output | 1 | One-cycle pulse per accepted exchange |
| disp_valid | output | 1 | One-cycle dispatch strobe to the handler |
| disp_cmd | output | 8 | Command byte being dispatched |
| disp_argc | output | ARG_W | Number of stored arguments (saturated at DEPTH) |
| disp_args | output | DEPTH*8 | Stored arguments, byte i in bits [8i+7:8i] |
| hdl_done | input | 1 | Handler answer is valid this cycle |
| hdl_unknown | input | 1 | Handler does not recognise the command |
| hdl_rsp_len | input | ARG_W | Handler response size in bytes |
| hdl_rsp_bytes | input | DEPTH*8 | Handler response, byte i in bits [8i+7:8i] |

## Verification
The command path is tried with several packet shapes:
- A zero-argument command, which must dispatch straight after its command byte.
- A fixed two-argument command.
- A variable-count command.
- A count longer than the buffer, which shows that storage saturates while completion still waits for the full count.

The answer path covers:
- A known fixed-length answer.
- A variable answer, whose leading size byte must come first.
- Unknown commands with fixed and with variable lengths, which tell zero-fill apart from an empty reply.

Wrong-direction requests in each state, same-value, both-low and both-high image writes, and a request made while the handler is busy show which port writes the engine must ignore.

// File: rtl/hsk_pkg.sv
`timescale 1ns/1ps
package hsk_pkg;
   localparam int ACK_POS = 3;
   localparam int REQ_POS = 4;
   localparam logic [7:0] LEN_VAR = 8'hFF;
   localparam logic [7:0] PB_IDLE = 8'h18;

   typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_WAIT, ST_RSP} hsk_state_e;
   // entry: [15:8] argument length, [7:0] response length, 0xFF = variable
   typedef logic [255:0][15:0] hsk_len_tab_t;

   function automatic hsk_len_tab_t hsk_default_lens();
      hsk_len_tab_t t;
      logic [7:0] cb;
      for (int c = 0; c < 256; c++) begin
         cb = 8'(c);
         if (cb[7:6] == 2'b11) t[c] = {LEN_VAR, LEN_VAR};
         else                  t[c] = {5'd0, cb[2:0], 5'd0, cb[5:3]};
      end
      return t;
   endfunction
endpackage

// File: rtl/hsk_pb_sync.sv
`timescale 1ns/1ps
module hsk_pb_sync #(
   parameter logic [7:0] RESET_IMG = hsk_pkg::PB_IDLE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] pb_in,
   input  logic       block_req,
   output logic [7:0] image,
   output logic       ev_req
);
   import hsk_pkg::*;

   logic changed, is_req, is_rel;
   assign changed = wr && (pb_in != image);
   assign is_req  = changed && !pb_in[REQ_POS] &&  pb_in[ACK_POS];
   assign is_rel  = changed &&  pb_in[REQ_POS] && !pb_in[ACK_POS];
   assign ev_req  = is_req && !block_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                image <= RESET_IMG;
      else if (is_rel)           image <= pb_in | (8'h01 << ACK_POS);
      else if (ev_req)           image <= pb_in & ~(8'h01 << ACK_POS);
      else if (changed && !is_req) image <= pb_in;
   end

   assert_req_clears_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_req |=> !image[ACK_POS]);
   assert_release_sets_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && pb_in[REQ_POS] && !pb_in[ACK_POS] && pb_in != image) |=> image[ACK_POS]);
   assert_same_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && pb_in == image) |=> $stable(image));
endmodule

// File: rtl/hsk_len_rom.sv
`timescale 1ns/1ps
module hsk_len_rom #(
   parameter hsk_pkg::hsk_len_tab_t TAB = hsk_pkg::hsk_default_lens()
) (
   input  logic [7:0] addr,
   output logic [7:0] arg_len,
   output logic [7:0] rsp_len
);
   assign {arg_len, rsp_len} = TAB[addr];
endmodule

// File: rtl/hsk_arg_store.sv
`timescale 1ns/1ps
module hsk_arg_store #(
   parameter int DEPTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [7:0]         widx,
   input  logic [7:0]         wbyte,
   output logic [DEPTH*8-1:0] flat
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (we) begin
         for (int i = 0; i < DEPTH; i++)
            if (widx == 8'(i)) mem[i] <= wbyte;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign flat[g*8 +: 8] = mem[g];
   end
endmodule

// File: rtl/hsk_rsp_store.sv
`timescale 1ns/1ps
module hsk_rsp_store #(
   parameter int DEPTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld,
   input  logic               ld_zero,
   input  logic [DEPTH*8-1:0] ld_data,
   input  logic [7:0]         ridx,
   output logic [7:0]         rbyte
);
   localparam int IDX_W = $clog2(DEPTH);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (ld) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ld_zero ? 8'h00 : ld_data[i*8 +: 8];
      end
   end

   if ((1 << IDX_W) == DEPTH) begin : g_pow2
      assign rbyte = (ridx[7:IDX_W] == '0) ? mem[ridx[IDX_W-1:0]] : 8'h00;
   end else begin : g_any
      assign rbyte = (ridx < 8'(DEPTH)) ? mem[ridx[IDX_W-1:0]] : 8'h00;
   end
endmodule

// File: rtl/hsk_cmd_engine.sv
`timescale 1ns/1ps
module hsk_cmd_engine #(
   parameter int DEPTH = 32,
   parameter hsk_pkg::hsk_len_tab_t LEN_TAB = hsk_pkg::hsk_default_lens(),
   localparam int ARG_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_wr,
   input  logic [7:0]         host_pb,
   input  logic               host_sr_out,
   input  logic [7:0]         host_sr_byte,
   output logic [7:0]         pb_image,
   output logic [7:0]         sr_byte,
   output logic               sr_irq,
   output logic               disp_valid,
   output logic [7:0]         disp_cmd,
   output logic [ARG_W-1:0]   disp_argc,
   output logic [DEPTH*8-1:0] disp_args,
   input  logic               hdl_done,
   input  logic               hdl_unknown,
   input  logic [ARG_W-1:0]   hdl_rsp_len,
   input  logic [DEPTH*8-1:0] hdl_rsp_bytes
);
   import hsk_pkg::*;

   initial begin
      assert_depth_range: assert (DEPTH >= 2 && DEPTH <= 128)
         else $error("hsk_cmd_engine: DEPTH must lie in 2..128");
   end

   hsk_state_e st_q, st_n;
   logic [7:0] cmd_q, cmd_n, clen_q, clen_n, rlen_q, rlen_n;
   logic [7:0] rx_q, rx_n, tx_q, tx_n, rsz_q, rsz_n, srb_q, srb_n;
   logic       cvar_q, cvar_n, rvar_q, rvar_n;
   logic       irq_q, irq_n, disp_q, disp_n, arg_we, rsp_ld;
   logic       ev_req;
   logic [7:0] tab_arg, tab_rsp, rsp_rb, hdl_len8, tx_byte;

   hsk_pb_sync u_pb (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .pb_in(host_pb),
      .block_req(st_q == ST_WAIT), .image(pb_image), .ev_req(ev_req));

   hsk_len_rom #(.TAB(LEN_TAB)) u_rom (
      .addr(host_sr_byte), .arg_len(tab_arg), .rsp_len(tab_rsp));

   hsk_arg_store #(.DEPTH(DEPTH)) u_args (
      .clk(clk), .rst_n(rst_n), .we(arg_we), .widx(rx_q),
      .wbyte(host_sr_byte), .flat(disp_args));

   hsk_rsp_store #(.DEPTH(DEPTH)) u_rsp (
      .clk(clk), .rst_n(rst_n), .ld(rsp_ld), .ld_zero(hdl_unknown),
      .ld_data(hdl_rsp_bytes), .ridx(tx_q), .rbyte(rsp_rb));

   assign hdl_len8 = (8'(hdl_rsp_len) > 8'(DEPTH)) ? 8'(DEPTH) : 8'(hdl_rsp_len);
   assign tx_byte  = (tx_q < rsz_q) ? rsp_rb : 8'h00;

   always_comb begin
      st_n = st_q;   cmd_n = cmd_q;   cvar_n = cvar_q; clen_n = clen_q;
      rvar_n = rvar_q; rlen_n = rlen_q; rx_n = rx_q;   tx_n = tx_q;
      rsz_n = rsz_q; srb_n = srb_q;
      irq_n = 1'b0;  disp_n = 1'b0;   arg_we = 1'b0;  rsp_ld = 1'b0;
      unique case (st_q)
         ST_IDLE: if (ev_req && host_sr_out) begin
            irq_n  = 1'b1;
            cmd_n  = host_sr_byte;
            cvar_n = (tab_arg == LEN_VAR);
            clen_n = tab_arg;
            rvar_n = (tab_rsp == LEN_VAR);
            rlen_n = tab_rsp;
            rx_n   = 8'd0;
            tx_n   = 8'd0;
            if (tab_arg == 8'd0) begin
               disp_n = 1'b1;
               st_n   = ST_WAIT;
            end else begin
               st_n   = ST_CMD;
            end
         end
         ST_CMD: if (ev_req && host_sr_out) begin
            irq_n = 1'b1;
            if (cvar_q) begin
               cvar_n = 1'b0;
               clen_n = host_sr_byte;
               if (host_sr_byte == 8'd0) begin
                  disp_n = 1'b1;
                  st_n   = ST_WAIT;
               end
            end else begin
               arg_we = 1'b1;
               rx_n   = rx_q + 8'd1;
               if (rx_q + 8'd1 == clen_q) begin
                  disp_n = 1'b1;
                  st_n   = ST_WAIT;
               end
            end
         end
         ST_WAIT: if (hdl_done) begin
            rsp_ld = 1'b1;
            rsz_n  = hdl_unknown ? (rvar_q ? 8'd0 : rlen_q) : hdl_len8;
            st_n   = (!rvar_q && rlen_q == 8'd0) ? ST_IDLE : ST_RSP;
         end
         ST_RSP: if (ev_req && !host_sr_out) begin
            irq_n = 1'b1;
            if (rvar_q) begin
               rvar_n = 1'b0;
               rlen_n = rsz_q;
               srb_n  = rsz_q;
               if (rsz_q == 8'd0) st_n = ST_IDLE;
            end else begin
               srb_n = tx_byte;
               tx_n  = tx_q + 8'd1;
               if (tx_q + 8'd1 == rlen_q) st_n = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE; cmd_q <= '0; cvar_q <= 1'b0; clen_q <= '0;
         rvar_q <= 1'b0; rlen_q <= '0; rx_q <= '0; tx_q <= '0;
         rsz_q <= '0; srb_q <= '0; irq_q <= 1'b0; disp_q <= 1'b0;
      end else begin
         st_q <= st_n; cmd_q <= cmd_n; cvar_q <= cvar_n; clen_q <= clen_n;
         rvar_q <= rvar_n; rlen_q <= rlen_n; rx_q <= rx_n; tx_q <= tx_n;
         rsz_q <= rsz_n; srb_q <= srb_n; irq_q <= irq_n; disp_q <= disp_n;
      end
   end

   assign sr_byte    = srb_q;
   assign sr_irq     = irq_q;
   assign disp_valid = disp_q;
   assign disp_cmd   = cmd_q;
   assign disp_argc  = (rx_q > 8'(DEPTH)) ? ARG_W'(DEPTH) : rx_q[ARG_W-1:0];

   assert_irq_from_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
      sr_irq |-> $past(ev_req));
   assert_single_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |=> !disp_valid);
   assert_wait_silent_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |=> !sr_irq);
   assert_dispatch_enters_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> (st_q == ST_WAIT));
   assert_rsp_dir_error_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RSP && ev_req && host_sr_out) |=> (!sr_irq && $stable(sr_byte)));
endmodule

// File: tb/hsk_cmd_engine_tb.sv
`timescale 1ns/1ps
module hsk_cmd_engine_tb;
   localparam int DEPTH = 32;
   localparam int AW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, host_wr, host_sr_out, sr_irq, disp_valid, hdl_done, hdl_unknown;
   logic [7:0] host_pb, host_sr_byte, pb_image, sr_byte, disp_cmd;
   logic [AW-1:0] disp_argc, hdl_rsp_len;
   logic [DEPTH*8-1:0] disp_args, hdl_rsp_bytes;

   hsk_cmd_engine #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_pb(host_pb),
      .host_sr_out(host_sr_out), .host_sr_byte(host_sr_byte),
      .pb_image(pb_image), .sr_byte(sr_byte), .sr_irq(sr_irq),
      .disp_valid(disp_valid), .disp_cmd(disp_cmd), .disp_argc(disp_argc),
      .disp_args(disp_args), .hdl_done(hdl_done), .hdl_unknown(hdl_unknown),
      .hdl_rsp_len(hdl_rsp_len), .hdl_rsp_bytes(hdl_rsp_bytes));

   int checks = 0, errors = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic [7:0] cmd;
      int argc;
      logic [DEPTH*8-1:0] args;
   } disp_rec_t;
   disp_rec_t exp_q[$];

   // scoreboard monitor: compares every dispatch with the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         if (disp_valid) begin
            if (exp_q.size() == 0) begin
               chk("R9", "unexpected dispatch", 32'(disp_cmd), 32'hFFFF);
            end else begin
               disp_rec_t r;
               logic [DEPTH*8-1:0] mask;
               r = exp_q.pop_front();
               mask = '0;
               for (int i = 0; i < r.argc; i++) mask[i*8 +: 8] = 8'hFF;
               chk("R9", "dispatch cmd", 32'(disp_cmd), 32'(r.cmd));
               chk("R8/R9", "dispatch argc", 32'(disp_argc), 32'(r.argc));
               chk("R7/R8", "dispatch args", (disp_args & mask) == (r.args & mask), 1);
            end
         end
      end
   end

   // handler model: answers six cycles after a dispatch
   int h_len = 0;
   bit h_unk = 1'b0;
   initial begin
      hdl_done = 1'b0; hdl_unknown = 1'b0; hdl_rsp_len = '0; hdl_rsp_bytes = '0;
      forever begin
         @(negedge clk);
         if (disp_valid) begin
            logic [7:0] c;
            c = disp_cmd;
            repeat (6) @(negedge clk);
            hdl_done = 1'b1; hdl_unknown = h_unk; hdl_rsp_len = AW'(h_len);
            for (int i = 0; i < DEPTH; i++) hdl_rsp_bytes[i*8 +: 8] = c + 8'(i) + 8'd1;
            @(negedge clk);
            hdl_done = 1'b0;
         end
      end
   end

   task automatic host_write(input logic [7:0] pb, input bit dout, input logic [7:0] b);
      @(negedge clk);
      host_wr = 1'b1; host_pb = pb; host_sr_out = dout; host_sr_byte = b;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic req_byte(input bit dout, input logic [7:0] b,
                           output logic irq, output logic [7:0] rb, output logic [7:0] img);
      host_write(8'h08, dout, b);
      irq = sr_irq; rb = sr_byte; img = pb_image;
      host_write(8'h10, dout, b);
      chk("R2", "release image", 32'(pb_image), 32'h18);
      chk("R2", "release irq", 32'(sr_irq), 0);
   endtask

   task automatic send_ok(input logic [7:0] b, input string req);
      logic irq; logic [7:0] rb, img;
      req_byte(1'b1, b, irq, rb, img);
      chk("R4", "ack cleared", 32'(img), 32'h00);
      chk("R13", {req, " irq on host byte"}, 32'(irq), 1);
   endtask

   task automatic read_ok(input logic [7:0] exp, input string req);
      logic irq; logic [7:0] rb, img;
      req_byte(1'b0, 8'h00, irq, rb, img);
      chk(req, "response byte", 32'(rb), 32'(exp));
      chk("R13", "irq on response byte", 32'(irq), 1);
   endtask

   task automatic push(input logic [7:0] c, input int n, input logic [DEPTH*8-1:0] a);
      disp_rec_t r;
      r.cmd = c; r.argc = n; r.args = a;
      exp_q.push_back(r);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic irq; logic [7:0] rb, img;
      logic [DEPTH*8-1:0] a;
      rst_n = 1'b0; host_wr = 1'b0; host_pb = 8'h18; host_sr_out = 1'b0; host_sr_byte = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "image", 32'(pb_image), 32'h18);
      chk("R1", "irq", 32'(sr_irq), 0);
      chk("R1", "disp", 32'(disp_valid), 0);
      chk("R1", "sr_byte", 32'(sr_byte), 0);

      // R3 same-value, both-low, both-high writes
      host_write(8'h18, 1'b1, 8'h55);
      chk("R3", "same write image", 32'(pb_image), 32'h18);
      chk("R3", "same write irq", 32'(sr_irq), 0);
      host_write(8'h00, 1'b1, 8'h55);
      chk("R3", "both low image", 32'(pb_image), 32'h00);
      chk("R3", "both low irq", 32'(sr_irq), 0);
      host_write(8'h18, 1'b1, 8'h55);
      chk("R3", "both high image", 32'(pb_image), 32'h18);
      chk("R3", "both high irq", 32'(sr_irq), 0);

      // R5 wrong direction in idle: ack still cleared, nothing latched
      req_byte(1'b0, 8'h1A, irq, rb, img);
      chk("R5", "idle error ack", 32'(img), 32'h00);
      chk("R5", "idle error irq", 32'(irq), 0);

      // R6/R9 zero-length command dispatches at once, zero response
      h_len = 0; h_unk = 1'b0;
      push(8'h00, 0, '0);
      send_ok(8'h00, "R6");
      repeat (10) @(negedge clk);

      // R6 fixed 2 args / 3 response bytes, with R5 and R12 errors inside
      a = '0; a[7:0] = 8'hA1; a[15:8] = 8'hB2;
      h_len = 3;
      push(8'h1A, 2, a);
      send_ok(8'h1A, "R6");
      send_ok(8'hA1, "R6");
      req_byte(1'b0, 8'hEE, irq, rb, img);
      chk("R5", "cmd error irq", 32'(irq), 0);
      send_ok(8'hB2, "R6");
      repeat (10) @(negedge clk);
      read_ok(8'h1B, "R10");
      req_byte(1'b1, 8'h77, irq, rb, img);
      chk("R12", "rsp error irq", 32'(irq), 0);
      chk("R12", "rsp error byte held", 32'(rb), 32'h1B);
      read_ok(8'h1C, "R10");
      read_ok(8'h1D, "R10");

      // R7 variable count, R14 request during handler wait, R11 size byte
      a = '0; a[7:0] = 8'h11; a[15:8] = 8'h22; a[23:16] = 8'h33; a[31:24] = 8'h44;
      h_len = 2;
      push(8'hC5, 4, a);
      send_ok(8'hC5, "R7");
      send_ok(8'h04, "R7");
      for (int i = 0; i < 4; i++) send_ok(a[i*8 +: 8], "R7");
      req_byte(1'b0, 8'h00, irq, rb, img);
      chk("R14", "wait request image", 32'(img), 32'h18);
      chk("R14", "wait request irq", 32'(irq), 0);
      repeat (10) @(negedge clk);
      read_ok(8'h02, "R11");
      read_ok(8'hC6, "R11");
      read_ok(8'hC7, "R11");

      // R8 overflow: 40 arguments, 32 kept
      a = '0;
      for (int i = 0; i < DEPTH; i++) a[i*8 +: 8] = 8'(i * 3 + 1);
      h_len = 0;
      push(8'hC0, DEPTH, a);
      send_ok(8'hC0, "R8");
      send_ok(8'd40, "R8");
      for (int i = 0; i < 40; i++) send_ok(8'(i * 3 + 1), "R8");
      repeat (10) @(negedge clk);
      read_ok(8'h00, "R11");

      // R10 unknown command, fixed response length 4 -> zeros
      a = '0; a[7:0] = 8'h5A;
      h_len = 7; h_unk = 1'b1;
      push(8'h21, 1, a);
      send_ok(8'h21, "R10");
      send_ok(8'h5A, "R10");
      repeat (10) @(negedge clk);
      for (int i = 0; i < 4; i++) read_ok(8'h00, "R10");

      // R10 unknown command, variable response -> size zero
      push(8'hC1, 0, '0);
      send_ok(8'hC1, "R10");
      send_ok(8'h00, "R10");
      repeat (10) @(negedge clk);
      read_ok(8'h00, "R10");

      // R14 back in idle: immediate-dispatch command with one response byte
      h_unk = 1'b0; h_len = 1;
      push(8'h08, 0, '0);
      send_ok(8'h08, "R14");
      repeat (10) @(negedge clk);
      read_ok(8'h09, "R14");

      repeat (4) @(negedge clk);
      chk("R9", "all dispatches seen", 32'(exp_q.size()), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule